// File: doc/BRIEF.md
# Dual-Core Mailbox with Cross-Connected Word FIFOs

This block lets two processor cores pass 32-bit words to each other. It holds two small FIFOs, one for each direction. Each core sees the same three word-addressed registers: a status register, a transmit register and a receive register. The core-identity bit that comes with each access decides the mapping. A core with identity `k` pushes into FIFO `k` and pops from FIFO `1-k`. A word that one core sends can therefore only be collected by the other core. Two bus ports are provided, and either port may carry either identity.

Each core has its own receive interrupt and its own pair of sticky error flags. One flag records a write that was dropped because the FIFO was full. The other records a read of an empty FIFO. A write of any value to the status register clears both flags for that core. When a word is accepted, the receiving core gets a one-cycle event pulse that can wake it from a wait-for-event state. Software drains its incoming FIFO by reading the receive register until the valid bit clears. Because the interrupt also carries the error flags, an interrupt handler must check the valid bit before it reads.

Top module: `ipc_mailbox`

## Requirements
- R1: A word written by core k is returned only by reads of the receive register made by core 1-k, and words come out in the order they were written.
- R2: Each direction stores DEPTH words (4 by default). With DEPTH words stored, the ready bit (status bit 1) of the sending core reads 0.
- R3: A write to a full FIFO with no pop of that FIFO in the same cycle is dropped and sets the sender's sticky overflow bit (status bit 2). If the other core pops the same FIFO in that cycle, the write is accepted and no overflow is recorded.
- R4: A read of the receive register while the incoming FIFO is empty returns 0 and sets the reader's sticky underflow bit (status bit 3). A write that arrives in that same cycle is still stored.
- R5: Status bit 0 (valid) is 1 exactly when the core's incoming FIFO holds at least one word. Bits 31:4 read 0.
- R6: A write of any value to the status register clears bits 2 and 3 for the writing core only. The other core's flags are left unchanged, and the valid and ready bits are unaffected.
- R7: `irq[k]` equals valid OR overflow OR underflow of core k's view, so it can be high while that FIFO is empty.
- R8: One cycle after a word from core k is accepted, `evt[1-k]` is high for that cycle. A dropped write raises no pulse.
- R9: The identity bit of each access, not the port it arrives on, selects the FIFOs. If both ports present the same identity in one cycle, port 0 is served.
- R10: After reset both FIFOs are empty, both status registers read 2 (ready set, all else clear), and `irq` and `evt` are 0.
- R11: Register word addresses are 0 for status, 1 for transmit and 2 for receive. Reads of transmit or of address 3 return 0, and writes to receive or to address 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | NPORT | Access strobe per port |
| bus_we | input | NPORT | 1 = write, 0 = read, per port |
| bus_core | input | NPORT | Identity of the core issuing the access on each port |
| bus_addr | input | NPORT x 2 | Register word address per port |
| bus_wdata | input | NPORT x DATA_W | Write data per port |
| bus_rdata | output | NPORT x DATA_W | Read data per port, valid in the cycle of the access |
| irq | output | 2 | Receive interrupt per core |
| evt | output | 2 | One-cycle wake event per core |

## Verification
The interesting overlap is a push and a pop on the same FIFO in the same cycle, made by the two cores through the two ports. The bench drives both ports in one cycle in two cases. In the first, the FIFO is full: the word must be accepted without an overflow flag, and it must appear later in the drain in its proper order. In the second, the FIFO is empty: the read must return 0 and set underflow, while the concurrent write must still be stored and be returned by the next read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int NCORE = 2;
  localparam int REG_AW = 2;
  localparam int STAT_W = 4;

  typedef enum logic [REG_AW-1:0] {
    REG_STAT = 2'd0,
    REG_TX   = 2'd1,
    REG_RX   = 2'd2,
    REG_NONE = 2'd3
  } mbx_reg_e;

  localparam int ST_VLD = 0;
  localparam int ST_RDY = 1;
  localparam int ST_OVF = 2;
  localparam int ST_UNF = 3;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic              push_ok,
  output logic              pop_ok,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ptr_en;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CAP);
  assign pop_ok  = pop_req & ~empty;
  assign push_ok = push_req & (~full | pop_ok);
  assign head    = empty ? '0 : mem_q[rd_q];
  assign ptr_en  = push_ok | pop_ok;

  always_comb begin
    wr_d  = push_ok ? bump(wr_q) : wr_q;
    rd_d  = pop_ok  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (push_ok && !pop_ok) cnt_d = cnt_q + 1'b1;
    if (pop_ok && !push_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ovf,
  input  logic set_unf,
  input  logic clr,
  output logic ovf,
  output logic unf
);
  logic ovf_d, unf_d, flag_en;

  assign flag_en = set_ovf | set_unf | clr;

  always_comb begin
    ovf_d = set_ovf | (ovf & ~clr);
    unf_d = set_unf | (unf & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf <= 1'b0;
      unf <= 1'b0;
    end else if (flag_en) begin
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end
endmodule

// File: rtl/mbx_route.sv
module mbx_route
  import mbx_pkg::*;
#(
  parameter int NPORT  = 2,
  parameter int DATA_W = 32
) (
  input  logic [NPORT-1:0]             p_en,
  input  logic [NPORT-1:0]             p_we,
  input  logic [NPORT-1:0]             p_core,
  input  logic [NPORT-1:0][REG_AW-1:0] p_addr,
  input  logic [NPORT-1:0][DATA_W-1:0] p_wdata,
  output logic [NCORE-1:0]             c_wr_tx,
  output logic [NCORE-1:0]             c_rd_rx,
  output logic [NCORE-1:0]             c_wr_stat,
  output logic [NCORE-1:0][DATA_W-1:0] c_wdata
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic              hit;
    logic              we;
    logic [REG_AW-1:0] addr;
    logic [DATA_W-1:0] data;

    always_comb begin
      hit  = 1'b0;
      we   = 1'b0;
      addr = REG_NONE;
      data = '0;
      for (int p = NPORT - 1; p >= 0; p--) begin
        if (p_en[p] && (p_core[p] == 1'(c))) begin
          hit  = 1'b1;
          we   = p_we[p];
          addr = p_addr[p];
          data = p_wdata[p];
        end
      end
    end

    assign c_wr_tx[c]   = hit &  we & (addr == REG_TX);
    assign c_rd_rx[c]   = hit & ~we & (addr == REG_RX);
    assign c_wr_stat[c] = hit &  we & (addr == REG_STAT);
    assign c_wdata[c]   = data;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter int NPORT  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             bus_en,
  input  logic [NPORT-1:0]             bus_we,
  input  logic [NPORT-1:0]             bus_core,
  input  logic [NPORT-1:0][REG_AW-1:0] bus_addr,
  input  logic [NPORT-1:0][DATA_W-1:0] bus_wdata,
  output logic [NPORT-1:0][DATA_W-1:0] bus_rdata,
  output logic [NCORE-1:0]             irq,
  output logic [NCORE-1:0]             evt
);
  logic srst_n;

  logic [NCORE-1:0]             c_wr_tx, c_rd_rx, c_wr_stat;
  logic [NCORE-1:0][DATA_W-1:0] c_wdata;

  logic [NCORE-1:0]             f_push_req, f_push_ok, f_pop_req, f_pop_ok;
  logic [NCORE-1:0]             f_empty, f_full;
  logic [NCORE-1:0][DATA_W-1:0] f_head;

  logic [NCORE-1:0]             ovf_q, unf_q, stat_clr;
  logic [NCORE-1:0][STAT_W-1:0] status;
  logic [NCORE-1:0]             evt_d;

  mbx_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  mbx_route #(.NPORT(NPORT), .DATA_W(DATA_W)) u_route (
    .p_en      (bus_en),
    .p_we      (bus_we),
    .p_core    (bus_core),
    .p_addr    (bus_addr),
    .p_wdata   (bus_wdata),
    .c_wr_tx   (c_wr_tx),
    .c_rd_rx   (c_rd_rx),
    .c_wr_stat (c_wr_stat),
    .c_wdata   (c_wdata)
  );

  // FIFO c carries words sent by core c toward core 1-c.
  for (genvar c = 0; c < NCORE; c++) begin : g_dir
    assign f_push_req[c] = c_wr_tx[c];
    assign f_pop_req[c]  = c_rd_rx[NCORE-1-c];
    assign stat_clr[c]   = c_wr_stat[c];

    mbx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (srst_n),
      .push_req  (f_push_req[c]),
      .push_data (c_wdata[c]),
      .pop_req   (f_pop_req[c]),
      .push_ok   (f_push_ok[c]),
      .pop_ok    (f_pop_ok[c]),
      .head      (f_head[c]),
      .empty     (f_empty[c]),
      .full      (f_full[c])
    );

    mbx_flags u_flags (
      .clk     (clk),
      .rst_n   (srst_n),
      .set_ovf (f_push_req[c] & ~f_push_ok[c]),
      .set_unf (c_rd_rx[c] & ~f_pop_ok[NCORE-1-c]),
      .clr     (stat_clr[c]),
      .ovf     (ovf_q[c]),
      .unf     (unf_q[c])
    );

    always_comb begin
      status[c]         = '0;
      status[c][ST_VLD] = ~f_empty[NCORE-1-c];
      status[c][ST_RDY] = ~f_full[c];
      status[c][ST_OVF] = ovf_q[c];
      status[c][ST_UNF] = unf_q[c];
    end

    assign irq[c]   = status[c][ST_VLD] | ovf_q[c] | unf_q[c];
    assign evt_d[c] = f_push_ok[NCORE-1-c];
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) evt <= '0;
    else         evt <= evt_d;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic own;
    assign own = bus_core[p];

    always_comb begin
      bus_rdata[p] = '0;
      if (bus_en[p] && !bus_we[p]) begin
        unique case (bus_addr[p])
          REG_STAT: bus_rdata[p] = DATA_W'(status[own]);
          REG_RX:   bus_rdata[p] = f_head[~own];
          default:  bus_rdata[p] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NC-1:0] push_req,
  input logic [NC-1:0] push_ok,
  input logic [NC-1:0] pop_ok,
  input logic [NC-1:0] pop_req,
  input logic [NC-1:0] empty,
  input logic [NC-1:0] full,
  input logic [NC-1:0] ovf,
  input logic [NC-1:0] unf,
  input logic [NC-1:0] clr,
  input logic [NC-1:0] evt,
  input logic [NC-1:0] irq
);
  for (genvar c = 0; c < NC; c++) begin : g_c
    a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(full[c] && empty[c]));

    a_r3_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (full[c] && push_req[c] && !pop_ok[c]) |=> (full[c] && ovf[c]));

    a_r4_empty_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (empty[c] && pop_req[c]) |=> unf[NC-1-c]);

    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf[c] && !clr[c]) |=> ovf[c]);

    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[c] && !push_req[c] && !pop_req[NC-1-c]) |=> (!ovf[c] && !unf[c]));

    a_r7_irq_on_data: assert property (@(posedge clk) disable iff (!rst_n)
      !empty[c] |-> irq[NC-1-c]);

    a_r8_event_after_push: assert property (@(posedge clk) disable iff (!rst_n)
      push_ok[c] |=> evt[NC-1-c]);

    a_r8_no_event_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !push_ok[c] |=> !evt[NC-1-c]);
  end
endmodule

bind ipc_mailbox mbx_chk #(.NC(2)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .push_req (f_push_req),
  .push_ok  (f_push_ok),
  .pop_ok   (f_pop_ok),
  .pop_req  (f_pop_req),
  .empty    (f_empty),
  .full     (f_full),
  .ovf      (ovf_q),
  .unf      (unf_q),
  .clr      (stat_clr),
  .evt      (evt),
  .irq      (irq)
);

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int DW = 32;

  logic                 clk;
  logic                 rst_n;
  logic [1:0]           en, we, cid;
  logic [1:0][1:0]      addr;
  logic [1:0][DW-1:0]   wdata, rdata;
  logic [1:0]           irq, evt;

  int nchk  = 0;
  int nfail = 0;

  ipc_mailbox u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (en),
    .bus_we    (we),
    .bus_core  (cid),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq),
    .evt       (evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        p;
    logic        c;
    logic        w;
    logic [1:0]  a;
    logic [31:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 1'b0, 1'b1, 2'd1, 32'h1111_1111, 32'h0},
    '{1'b0, 1'b0, 1'b1, 2'd1, 32'h2222_2222, 32'h0},
    '{1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 32'h3},
    '{1'b1, 1'b1, 1'b0, 2'd2, 32'h0, 32'h1111_1111},
    '{1'b0, 1'b1, 1'b1, 2'd1, 32'h3333_3333, 32'h0},
    '{1'b1, 1'b0, 1'b0, 2'd2, 32'h0, 32'h3333_3333},
    '{1'b1, 1'b1, 1'b0, 2'd2, 32'h0, 32'h2222_2222},
    '{1'b1, 1'b1, 1'b0, 2'd0, 32'h0, 32'h2},
    '{1'b0, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 2'd2, 32'hDEAD_BEEF, 32'h0},
    '{1'b0, 1'b0, 1'b0, 2'd0, 32'h0, 32'h2},
    '{1'b0, 1'b0, 1'b0, 2'd3, 32'h0, 32'h0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    en = '0; we = '0; cid = 2'b10; addr = '0; wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic drive(input int p, input logic c, input logic w,
                       input logic [1:0] a, input logic [31:0] d);
    en[p] = 1'b1; we[p] = w; cid[p] = c; addr[p] = a; wdata[p] = d;
  endtask

  task automatic wr(input int p, input logic c, input logic [1:0] a, input logic [31:0] d);
    drive(p, c, 1'b1, a, d);
    step();
  endtask

  task automatic rd(input int p, input logic c, input logic [1:0] a, output logic [31:0] v);
    drive(p, c, 1'b0, a, 32'h0);
    #2 v = rdata[p];
    step();
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 irq", 32'(irq), 32'h0);
    check("R10 evt", 32'(evt), 32'h0);
    rd(0, 1'b0, 2'd0, v); check("R10 core0 status", v, 32'h2);
    rd(1, 1'b1, 2'd0, v); check("R10 core1 status", v, 32'h2);

    // table walk: R1 R5 R9 R11
    for (int i = 0; i < 12; i++) begin
      if (VECS[i].w) begin
        wr(int'(VECS[i].p), VECS[i].c, VECS[i].a, VECS[i].d);
      end else begin
        rd(int'(VECS[i].p), VECS[i].c, VECS[i].a, v);
        check($sformatf("R1/R5/R9/R11 vector %0d", i), v, VECS[i].exp);
      end
    end

    // R8 event pulse timing
    wr(0, 1'b0, 2'd1, 32'hA000_0001);
    check("R8 pulse toward core1", 32'(evt), 32'h2);
    step();
    check("R8 pulse lasts one cycle", 32'(evt), 32'h0);

    // R2 fill to depth
    wr(0, 1'b0, 2'd1, 32'hA000_0002);
    wr(0, 1'b0, 2'd1, 32'hA000_0003);
    wr(0, 1'b0, 2'd1, 32'hA000_0004);
    rd(0, 1'b0, 2'd0, v); check("R2 full clears ready", v, 32'h0);
    check("R7 irq core1 on valid", 32'(irq), 32'h2);

    // R3 overflow drop
    wr(0, 1'b0, 2'd1, 32'hBAD0_0005);
    check("R8 no pulse on dropped write", 32'(evt), 32'h0);
    rd(0, 1'b0, 2'd0, v); check("R3 overflow flag", v, 32'h4);
    check("R7 irq on overflow with empty fifo", 32'(irq), 32'h3);

    // R6 clear own flags
    wr(0, 1'b0, 2'd0, 32'hFFFF_FFFF);
    rd(0, 1'b0, 2'd0, v); check("R6 clear core0", v, 32'h0);

    // R3 push into full FIFO while the other core pops it
    drive(0, 1'b0, 1'b1, 2'd1, 32'hA000_0006);
    drive(1, 1'b1, 1'b0, 2'd2, 32'h0);
    #2 v = rdata[1];
    step();
    check("R1 head during concurrent op", v, 32'hA000_0001);
    check("R3 accepted write raises event", 32'(evt), 32'h2);
    rd(0, 1'b0, 2'd0, v); check("R3 no overflow with concurrent pop", v, 32'h0);
    rd(1, 1'b1, 2'd2, v); check("R3 drain 1", v, 32'hA000_0002);
    rd(1, 1'b1, 2'd2, v); check("R3 drain 2", v, 32'hA000_0003);
    rd(1, 1'b1, 2'd2, v); check("R3 drain 3", v, 32'hA000_0004);
    rd(1, 1'b1, 2'd2, v); check("R3 drain 4 concurrent word", v, 32'hA000_0006);

    // R4 underflow
    rd(1, 1'b1, 2'd2, v); check("R4 empty read returns zero", v, 32'h0);
    rd(1, 1'b1, 2'd0, v); check("R4 underflow flag", v, 32'hA);
    check("R7 irq on underflow", 32'(irq), 32'h2);
    rd(0, 1'b0, 2'd0, v); check("R6 other core flags separate", v, 32'h2);
    wr(1, 1'b1, 2'd0, 32'h0);
    rd(1, 1'b1, 2'd0, v); check("R6 clear core1", v, 32'h2);
    check("R7 irq quiet", 32'(irq), 32'h0);

    // R4 empty read with concurrent write
    drive(0, 1'b1, 1'b0, 2'd2, 32'h0);
    drive(1, 1'b0, 1'b1, 2'd1, 32'hC0DE_0007);
    #2 v = rdata[0];
    step();
    check("R4 concurrent empty read zero", v, 32'h0);
    rd(1, 1'b1, 2'd0, v); check("R4 unf plus stored word", v, 32'hB);
    rd(1, 1'b1, 2'd2, v); check("R4 concurrent word kept", v, 32'hC0DE_0007);

    // R9 same identity on both ports: port 0 served
    drive(0, 1'b1, 1'b1, 2'd1, 32'h0000_00AA);
    drive(1, 1'b1, 1'b1, 2'd1, 32'h0000_00BB);
    step();
    rd(0, 1'b0, 2'd2, v); check("R9 port0 wins", v, 32'h0000_00AA);
    rd(0, 1'b0, 2'd0, v); check("R9 loser not stored", v, 32'h2);

    finish_run();
  end
endmodule